// File: doc/BRIEF.md
# Buffered Down-Counting Timer Channel

One channel of a multi-channel timer. Software writes a reload value and a compare value into two buffer registers. It then sets the channel's manual-update bit in a control word shared by all channels. While that bit is set, the live counter and the active compare value follow the buffers. Clearing manual update with start set releases the counter. From then on it steps down by one on every cycle in which the tick enable is high. When it leaves zero it either reloads from the buffers (periodic mode) or stops at zero (one-shot mode), and in both cases it latches a pending flag. The channel drives an output level that goes high once the count is at or below the active compare value, and an interrupt line.

The channel index is a parameter. It sets which offsets and which control bits the channel answers to. Control groups are four bits wide. Channel 0 owns group 0 and channel k≥1 owns group k+1, so group 1 is never used. The last channel (index 4) puts its auto-reload bit where the others have their invert bit, and it has no invert at all. The same index picks the channel's enable and pending bits in the shared interrupt register. Several instances sit on one write bus, and each one decodes only its own fields.

Top module: `tmr_chan`

## Requirements
- R1: A write to offset 0x0C+12·CH sets the count buffer and a write to offset 0x10+12·CH sets the compare buffer. Both keep only the low CNT_W bits of the data (for example 0x0001_0005 stores 5 when CNT_W=16).
- R2: In every cycle while the manual-update bit is set, the counter takes the count buffer and the active compare takes the compare buffer. The counter ignores ticks during that time.
- R3: When start is set and manual update is clear, each tick lowers the counter by one. A read at the observation offset returns the live count zero-extended. That offset is 0x14+12·CH, except 0x40 for CH=4, where a write to 0x40 still goes to the compare buffer.
- R4: With auto-reload set, a tick at count 0 reloads the counter and the active compare from the buffers. A count buffer of N gives N+1 ticks between expiries.
- R5: With auto-reload clear, a tick at count 0 makes the channel stop with the count held at 0. Further ticks do not move it until manual update is set again.
- R6: Clearing start halts the counter at its current value.
- R7: Writes to offset 0x08 set this channel's start, manual, invert and auto-reload bits. For CH≠4 these are bits 0, 1, 2 and 3 of group G, where G=0 for CH=0 and G=CH+1 otherwise. For CH=4 (bits 20–23) start is bit 20, manual is bit 21 and auto-reload is bit 22. That channel has no invert, and bit 23 is ignored. Bits of other groups have no effect.
- R8: The expiring tick sets the pending flag. Writing 1 to bit CH+5 of offset 0x44 clears it, and a set in the same cycle wins. A read of 0x44 shows the enable at bit CH and the pending flag at bit CH+5. Writes to 0x44 load the enable from bit CH.
- R9: irq_o is high exactly when the enable and the pending flag are both set.
- R10: The internal level is high when start is set, manual update is clear and count ≤ active compare. pwm_o is that level XOR the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | DATA_W | Read data (observation or interrupt register, else 0) |
| tick_i | input | 1 | Count enable, one step per high cycle |
| pwm_o | output | 1 | Output level |
| irq_o | output | 1 | Interrupt request |

## Verification
Random reload and compare values check the N+1 period, including N=0, where a design that reloads on reaching zero rather than on leaving it would fire one tick early. A second instance at index 4 catches the irregular control map. There, writing bit 22 must give periodic operation with an uninverted output, and bit 23 must give one-shot. The same instance catches the address overlap at 0x40, where the read must return the live count and not the compare buffer just written. The bench also drives a write of a 17-bit value, ticks during manual update, a stop followed by ticks, and expiry past a one-shot end. A design that skips truncation, counts through manual update, or restarts after one-shot shows a wrong observed count. Any instance that reacts to another channel's control group shows a wrong count as well.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef struct packed {
    logic start;
    logic manual;
    logic invert;
    logic autoreload;
  } tmr_ctl_t;

  localparam int unsigned CTL_OFS = 32'h08;
  localparam int unsigned IRQ_OFS = 32'h44;
  localparam int unsigned PEND_SHIFT = 5;
  localparam int unsigned LAST_CH = 4;

  function automatic int unsigned grp_of(input int unsigned ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction

  function automatic int unsigned cnt_buf_ofs(input int unsigned ch);
    return 32'h0C + 12 * ch;
  endfunction

  function automatic int unsigned cmp_buf_ofs(input int unsigned ch);
    return 32'h10 + 12 * ch;
  endfunction

  function automatic int unsigned obs_ofs(input int unsigned ch);
    return (ch == LAST_CH) ? 32'h40 : 32'h14 + 12 * ch;
  endfunction

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CH_IDX = 0
) (
  input  logic [3:0] nib_i,
  output tmr_ctl_t   ctl_o
);

  generate
    if (CH_IDX == LAST_CH) begin : g_last
      // displaced reload bit, no polarity control
      logic unused_nib;
      assign unused_nib       = nib_i[3];
      assign ctl_o.start      = nib_i[0];
      assign ctl_o.manual     = nib_i[1];
      assign ctl_o.invert     = 1'b0;
      assign ctl_o.autoreload = nib_i[2];
    end else begin : g_std
      assign ctl_o.start      = nib_i[0];
      assign ctl_o.manual     = nib_i[1];
      assign ctl_o.invert     = nib_i[2];
      assign ctl_o.autoreload = nib_i[3];
    end
  endgenerate

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             manual_i,
  input  logic             autoreload_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             level_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             done_q;
  logic             running;

  assign running  = start_i & ~manual_i & ~done_q;
  assign expire_o = running & tick_i & (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign level_o  = start_i & ~manual_i & (cnt_q <= cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      done_q <= 1'b0;
    end else if (manual_i) begin
      cnt_q  <= cnt_buf_i;
      cmp_q  <= cmp_buf_i;
      done_q <= 1'b0;
    end else if (running && tick_i) begin
      if (cnt_q == '0) begin
        if (autoreload_i) begin
          cnt_q <= cnt_buf_i;
          cmp_q <= cmp_buf_i;
        end else begin
          done_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_manual_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_i |=> (cnt_q == $past(cnt_buf_i)));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && autoreload_i) |=> (cnt_q == $past(cnt_buf_i)));

  p_oneshot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !autoreload_i) |=> (cnt_q == '0 && !expire_o));

  p_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !manual_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic wr_i,
  input  logic en_bit_i,
  input  logic clr_bit_i,
  output logic en_o,
  output logic pend_o,
  output logic irq_o
);

  logic en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) en_q <= en_bit_i;
      // a new expiry beats a simultaneous clear
      if (expire_i)                pend_q <= 1'b1;
      else if (wr_i && clr_bit_i)  pend_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = en_q & pend_q;

  p_pend_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pend_q);

  p_pend_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr_bit_i && !expire_i) |=> !pend_q);

  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expire_i && !pend_q) |=> !irq_o);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tick_i,
  output logic              pwm_o,
  output logic              irq_o
);

  localparam int unsigned GRP_LSB = 4 * grp_of(CH_IDX);
  localparam int unsigned PEND_BIT = CH_IDX + PEND_SHIFT;
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(cnt_buf_ofs(CH_IDX));
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(cmp_buf_ofs(CH_IDX));
  localparam logic [ADDR_W-1:0] A_OBS = ADDR_W'(obs_ofs(CH_IDX));
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(IRQ_OFS);

  logic [CNT_W-1:0] cnt_buf_q, cmp_buf_q, cnt;
  tmr_ctl_t         ctl_q, ctl_wr;
  logic             level, expire, en, pend, irq_wr;
  logic             unused_wdata;

  assign unused_wdata = ^wr_data_i;
  assign irq_wr       = wr_en_i && (wr_addr_i == A_IRQ);

  tmr_ctrl_decode #(.CH_IDX(CH_IDX)) u_dec (
    .nib_i (wr_data_i[GRP_LSB +: 4]),
    .ctl_o (ctl_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_buf_q <= '0;
      cmp_buf_q <= '0;
      ctl_q     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CNT) cnt_buf_q <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == A_CMP) cmp_buf_q <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == A_CTL) ctl_q     <= ctl_wr;
    end
  end

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .start_i      (ctl_q.start),
    .manual_i     (ctl_q.manual),
    .autoreload_i (ctl_q.autoreload),
    .cnt_buf_i    (cnt_buf_q),
    .cmp_buf_i    (cmp_buf_q),
    .cnt_o        (cnt),
    .level_o      (level),
    .expire_o     (expire)
  );

  tmr_irq_status u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .wr_i      (irq_wr),
    .en_bit_i  (wr_data_i[CH_IDX]),
    .clr_bit_i (wr_data_i[PEND_BIT]),
    .en_o      (en),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  assign pwm_o = level ^ ctl_q.invert;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_OBS) begin
      rd_data_o = DATA_W'(cnt);
    end else if (rd_addr_i == A_IRQ) begin
      rd_data_o[CH_IDX]   = en;
      rd_data_o[PEND_BIT] = pend;
    end
  end

  p_foreign_ctl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && wr_addr_i == A_CTL)) |=> $stable(ctl_q));

  p_no_invert_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CH_IDX == LAST_CH) |-> !ctl_q.invert);

endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_a, rd_b;
  logic        tick = 0;
  logic        pwm_a, pwm_b, irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chan #(.CH_IDX(2), .CNT_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_a),
    .tick_i(tick), .pwm_o(pwm_a), .irq_o(irq_a));

  tmr_chan #(.CH_IDX(4), .CNT_W(32)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_b),
    .tick_i(tick), .pwm_o(pwm_b), .irq_o(irq_b));

  function automatic int exp_period(input int n);
    return n + 1;
  endfunction

  function automatic logic exp_level(input int cnt, input int cmp, input bit inv);
    return (cnt <= cmp) ^ inv;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd(input logic [7:0] a);
    rd_addr = a; #1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] a_hold;
    void'($urandom(32'd1234));
    idle(2); rst_n = 1; idle(1);

    // reset state
    rd(8'h2C); chk("R3 reset obs a", rd_a, 0);
    rd(8'h40); chk("R3 reset obs b", rd_b, 0);
    chk("R10 reset pwm", {pwm_a, pwm_b}, 0);
    chk("R9 reset irq", {irq_a, irq_b}, 0);

    // channel 2: group 3, bits 12..15
    wr(8'h24, 32'h0001_0005);
    wr(8'h28, 32'd2);
    wr(8'h08, 32'h1 << 13);
    idle(1);
    rd(8'h2C); chk("R1 truncated load", rd_a, 5);
    tk(3);
    rd(8'h2C); chk("R2 no count in manual", rd_a, 5);
    chk("R10 low in manual", pwm_a, 0);

    wr(8'h08, (32'h1 << 12) | (32'h1 << 15));
    chk("R10 above compare", pwm_a, exp_level(5, 2, 0));
    tk(1); rd(8'h2C); chk("R3 step", rd_a, 4);
    tk(2); rd(8'h2C); chk("R3 step2", rd_a, 2);
    chk("R10 at compare", pwm_a, exp_level(2, 2, 0));
    tk(2); rd(8'h2C); chk("R3 zero", rd_a, 0);
    rd(8'h44); chk("R8 not yet pending", rd_a, 0);
    tk(1); rd(8'h2C); chk("R4 reload", rd_a, 5);
    rd(8'h44); chk("R8 pending set", rd_a, 32'h80);
    chk("R9 disabled irq", irq_a, 0);
    chk("R10 low after reload", pwm_a, 0);

    wr(8'h44, 32'h4);
    rd(8'h44); chk("R8 enable readback", rd_a, 32'h84);
    chk("R9 irq asserted", irq_a, 1);
    wr(8'h44, 32'h84);
    rd(8'h44); chk("R8 w1c", rd_a, 32'h04);
    chk("R9 irq dropped", irq_a, 0);

    wr(8'h08, (32'h1 << 12) | (32'h1 << 15) | (32'h1 << 14));
    chk("R10 inverted", pwm_a, exp_level(5, 2, 1));

    wr(8'h08, 32'h1 << 15);
    tk(3); rd(8'h2C); chk("R6 halted", rd_a, 5);

    // one-shot
    wr(8'h08, 32'h1 << 13); idle(1);
    wr(8'h08, 32'h1 << 12);
    tk(6); rd(8'h2C); chk("R5 expired", rd_a, 0);
    rd(8'h44); chk("R8 oneshot pending", rd_a, 32'h84);
    chk("R9 oneshot irq", irq_a, 1);
    wr(8'h44, 32'h84);
    tk(3); rd(8'h2C); chk("R5 held at zero", rd_a, 0);
    rd(8'h44); chk("R5 no second expiry", rd_a, 32'h04);
    wr(8'h44, 32'h0);

    // random periods
    for (int it = 0; it < 15; it++) begin
      int n, c, kk, cnt_t;
      bit inv;
      n = $urandom_range(0, 30); c = $urandom_range(0, 30); inv = $urandom_range(0, 1);
      wr(8'h44, 32'h80);
      wr(8'h24, n); wr(8'h28, c);
      wr(8'h08, 32'h1 << 13); idle(1);
      wr(8'h08, (32'h1 << 12) | (32'h1 << 15) | (32'(inv) << 14));
      kk = $urandom_range(0, n);
      tk(kk);
      rd(8'h2C); chk("R3 random obs", rd_a, n - kk);
      chk("R10 random level", pwm_a, exp_level(n - kk, c, inv));
      cnt_t = kk;
      for (int g = 0; g < 100; g++) begin
        tk(1); cnt_t++;
        rd(8'h44);
        if (rd_a[7]) break;
      end
      chk("R4 random period", cnt_t, exp_period(n));
      rd(8'h2C); chk("R4 random reload", rd_a, n);
    end
    wr(8'h44, 32'h80);

    // channel 4: bits 20..22, compare buffer shares 0x40 with observation
    wr(8'h3C, 32'd3);
    wr(8'h40, 32'd1);
    wr(8'h08, 32'h1 << 21); idle(1);
    rd(8'h2C); a_hold = rd_a;
    rd(8'h40); chk("R3 obs at 0x40", rd_b, 3);
    wr(8'h08, (32'h1 << 20) | (32'h1 << 22));
    chk("R7 bit22 not invert", pwm_b, 0);
    tk(4); rd(8'h40); chk("R7 bit22 periodic", rd_b, 3);
    rd(8'h44); chk("R8 ch4 pending", rd_b, 32'h200);
    chk("R9 ch4 irq off", irq_b, 0);
    tk(2); rd(8'h40); chk("R10 ch4 count", rd_b, 1);
    chk("R10 ch4 level", pwm_b, exp_level(1, 1, 0));
    wr(8'h08, 32'h1 << 21); idle(1);
    wr(8'h08, (32'h1 << 20) | (32'h1 << 23));
    tk(6); rd(8'h40); chk("R7 bit23 ignored oneshot", rd_b, 0);
    rd(8'h2C); chk("R7 foreign group ignored", rd_a, a_hold);

    summary();
  end
endmodule